// File: doc/BRIEF.md
# Quadrature Position Counter with Index Qualification

The block turns the two phase signals of an incremental encoder, plus its once-per-revolution index mark, into a signed-direction position count. Each legal phase transition is decoded into a single step and a direction. In x4 decoding every edge of either phase counts. In x2 decoding only edges of phase A count. The count either returns to zero on a qualified index pulse, or wraps against a programmable upper bound. The phase, index and control inputs are assumed to be already synchronised to `clk`.

An index pulse qualifies only while the phases sit in a chosen state. That state is either programmed explicitly, or learned from the phases seen at the first index pulse after reset. When the counter is reset by the index, the block also watches for the count stepping one past the bound while counting up, or wrapping to all-ones while counting down. Either case means lines were lost or gained. The block then latches a sticky error flag and raises at most one error interrupt until software clears the flag. All interfaces are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `qenc_position_tracker`

## Requirements
- R1: With `mode`=3'b111 or 3'b110, every single-bit change of {A,B} moves `position` by one at the next clock edge. The up sequence is {A,B}=00,10,11,01 (A leads). The reverse sequence counts down. `direction` is 1 after an up step and 0 after a down step.
- R2: With `mode`=3'b101 or 3'b100, only changes of A move the count. Changes of B alone leave `position` unchanged.
- R3: A change of both phases in one cycle produces no step. Any `mode` with bit 2 at 0 produces no steps.
- R4: In wrap operation (`mode` 3'b101/3'b111, or 3'b100/3'b110 with `idx_reset_en`=0), an up step from `max_count` gives 0. A down step from 0 gives `max_count`.
- R5: In `mode` 3'b100/3'b110 with `idx_reset_en`=1, a qualified index event loads 0. This overrides a step in the same cycle.
- R6: When `idx_match[2]`=1, an index pulse qualifies only while {A,B} equals `idx_match[1:0]`.
- R7: When `idx_match[2]`=0, the {A,B} state at the first index pulse after reset is captured. That pulse qualifies, and every later pulse qualifies only in the captured state.
- R8: In the two index modes, `irq_index` is a one-cycle pulse at each qualified index rising event, whatever the value of `idx_reset_en`.
- R9: `index_level` shows the value of `index_in` one cycle later.
- R10: In index-reset operation, an up step that reaches `max_count`+1, or a down step that reaches all-ones, sets `count_err`. Counting continues afterwards.
- R11: `irq_err` pulses for one cycle when an error is set, unless `err_irq_dis`=1. While `count_err` stays set, further errors give no interrupt. An error that coincides with `err_clear` keeps the flag set and does pulse `irq_err`.
- R12: `err_clear`=1 clears `count_err` at the next edge. Synchronous `rst` zeroes `position`, all flags and the captured index state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_a | input | 1 | Encoder phase A |
| phase_b | input | 1 | Encoder phase B |
| index_in | input | 1 | Encoder index mark |
| mode | input | 3 | 100 x2+index, 101 x2+bound, 110 x4+index, 111 x4+bound, others off |
| idx_reset_en | input | 1 | Allow a qualified index to zero the count |
| idx_match | input | 3 | Bit 2 selects an explicit match; bits 1:0 give the {A,B} state |
| max_count | input | CNT_W | Upper bound of the count |
| err_irq_dis | input | 1 | Suppress the error interrupt |
| err_clear | input | 1 | Clear the sticky error flag |
| position | output | CNT_W | Current count |
| index_level | output | 1 | Registered index level |
| direction | output | 1 | Direction of the last step, 1 = up |
| count_err | output | 1 | Sticky position error flag |
| irq_err | output | 1 | One-cycle error interrupt |
| irq_index | output | 1 | One-cycle index interrupt |

## Verification
Two pairs of functions can collide in one cycle. The first is an index reset and an encoder step. The second is a new position error and a software clear of the error flag. The bench steps the phases into the matching state in the same cycle that the index rises, and expects the count to read zero rather than the stepped value. It also raises `err_clear` in the same cycle as the step that reaches the bound plus one, and expects the flag to stay set with a fresh interrupt pulse.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [2:0] {
    QM_OFF    = 3'b000,
    QM_X2_IDX = 3'b100,
    QM_X2_BND = 3'b101,
    QM_X4_IDX = 3'b110,
    QM_X4_BND = 3'b111
  } qenc_mode_e;

  typedef struct packed {
    logic step;
    logic up;
  } qenc_step_t;

  function automatic logic mode_active(input logic [2:0] m);
    return m[2];
  endfunction

  function automatic logic mode_x4(input logic [2:0] m);
    return m[2] & m[1];
  endfunction

  function automatic logic mode_index(input logic [2:0] m);
    return (m == QM_X2_IDX) || (m == QM_X4_IDX);
  endfunction

endpackage

// File: rtl/qenc_step_decode.sv
module qenc_step_decode
  import qenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       phase_a,
  input  logic       phase_b,
  input  logic       enable,
  input  logic       x4,
  output qenc_step_t st
);
  logic prev_a, prev_b, primed;
  logic a_chg, b_chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_a <= 1'b0;
      prev_b <= 1'b0;
      primed <= 1'b0;
    end else begin
      prev_a <= phase_a;
      prev_b <= phase_b;
      primed <= 1'b1;
    end
  end

  always_comb begin
    a_chg   = phase_a ^ prev_a;
    b_chg   = phase_b ^ prev_b;
    st.step = primed && enable && (a_chg ^ b_chg) && (x4 || a_chg);
    // A leading B: the new A differs from the old B
    st.up   = prev_b ^ phase_a;
  end

  // R3: a double phase change never yields a step
  assert_no_double_step_R3: assert property (@(posedge clk) disable iff (rst)
    (a_chg && b_chg) |-> !st.step);

  // R2: in x2 decoding B-only changes never step
  assert_x2_b_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (!x4 && b_chg && !a_chg) |-> !st.step);

endmodule

// File: rtl/qenc_index_qual.sv
module qenc_index_qual (
  input  logic       clk,
  input  logic       rst,
  input  logic       phase_a,
  input  logic       phase_b,
  input  logic       index_in,
  input  logic       enable,
  input  logic [2:0] idx_match,
  output logic       idx_evt
);
  logic [1:0] cur_ab, cap_ab;
  logic       captured, qual, qual_q, state_ok;

  always_comb begin
    cur_ab = {phase_a, phase_b};
    if (idx_match[2]) state_ok = (cur_ab == idx_match[1:0]);
    else              state_ok = !captured || (cur_ab == cap_ab);
    qual    = enable && index_in && state_ok;
    idx_evt = qual && !qual_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_q   <= 1'b0;
      captured <= 1'b0;
      cap_ab   <= 2'b00;
    end else begin
      qual_q <= qual;
      if (enable && index_in && !idx_match[2] && !captured) begin
        captured <= 1'b1;
        cap_ab   <= cur_ab;
      end
    end
  end

  // R7: once learned, the index state is held until reset
  assert_capture_hold_R7: assert property (@(posedge clk) disable iff (rst)
    captured |=> (captured && $stable(cap_ab)));

  // R6: an explicit match never qualifies in another phase state
  assert_match_state_R6: assert property (@(posedge clk) disable iff (rst)
    (idx_evt && idx_match[2]) |-> (cur_ab == idx_match[1:0]));

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  qenc_step_t       st,
  input  logic             idx_evt,
  input  logic             idx_reset_en,
  input  logic [CNT_W-1:0] max_count,
  input  logic             err_irq_dis,
  input  logic             err_clear,
  output logic [CNT_W-1:0] position,
  output logic             direction,
  output logic             count_err,
  output logic             irq_err,
  output logic             irq_index
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic             idx_mode, hard_idx, hit;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W:0]   bound_p1;

  always_comb begin
    idx_mode = mode_index(mode);
    hard_idx = idx_mode && idx_reset_en;
    bound_p1 = {1'b0, max_count} + 1'b1;
    nxt      = position;
    hit      = 1'b0;
    if (st.step) begin
      if (hard_idx) begin
        nxt = st.up ? position + 1'b1 : position - 1'b1;
        hit = st.up ? ({1'b0, nxt} == bound_p1) : (nxt == ALL_ONES);
      end else if (st.up) begin
        nxt = (position == max_count) ? '0 : position + 1'b1;
      end else begin
        nxt = (position == '0) ? max_count : position - 1'b1;
      end
    end
    if (hard_idx && idx_evt) begin
      nxt = '0;
      hit = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      position  <= '0;
      direction <= 1'b0;
      count_err <= 1'b0;
      irq_err   <= 1'b0;
      irq_index <= 1'b0;
    end else begin
      position  <= nxt;
      if (st.step) direction <= st.up;
      count_err <= hit | (count_err & ~err_clear);
      irq_err   <= hit & ~err_irq_dis & (~count_err | err_clear);
      irq_index <= idx_evt & idx_mode;
    end
  end

  // R5: a hard index event leaves a zero count
  assert_index_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (idx_evt && hard_idx) |=> (position == '0));

  // R11: an interrupt is only ever seen alongside a set flag
  assert_irq_has_flag_R11: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> count_err);

  // R11: the flag is sticky without a clear
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (count_err && !err_clear) |=> count_err);

  // R3: no step, no movement of the count
  assert_hold_without_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!st.step && !(hard_idx && idx_evt)) |=> $stable(position));

endmodule

// File: rtl/qenc_position_tracker.sv
module qenc_position_tracker
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             index_in,
  input  logic [2:0]       mode,
  input  logic             idx_reset_en,
  input  logic [2:0]       idx_match,
  input  logic [CNT_W-1:0] max_count,
  input  logic             err_irq_dis,
  input  logic             err_clear,
  output logic [CNT_W-1:0] position,
  output logic             index_level,
  output logic             direction,
  output logic             count_err,
  output logic             irq_err,
  output logic             irq_index
);
  qenc_step_t st;
  logic       idx_evt;

  qenc_step_decode u_dec (
    .clk     (clk),
    .rst     (rst),
    .phase_a (phase_a),
    .phase_b (phase_b),
    .enable  (mode_active(mode)),
    .x4      (mode_x4(mode)),
    .st      (st)
  );

  qenc_index_qual u_idx (
    .clk       (clk),
    .rst       (rst),
    .phase_a   (phase_a),
    .phase_b   (phase_b),
    .index_in  (index_in),
    .enable    (mode_index(mode)),
    .idx_match (idx_match),
    .idx_evt   (idx_evt)
  );

  qenc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .mode         (mode),
    .st           (st),
    .idx_evt      (idx_evt),
    .idx_reset_en (idx_reset_en),
    .max_count    (max_count),
    .err_irq_dis  (err_irq_dis),
    .err_clear    (err_clear),
    .position     (position),
    .direction    (direction),
    .count_err    (count_err),
    .irq_err      (irq_err),
    .irq_index    (irq_index)
  );

  always_ff @(posedge clk) begin
    if (rst) index_level <= 1'b0;
    else     index_level <= index_in;
  end

  // R9: the status bit follows the index input by one cycle
  assert_index_level_R9: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(index_in) |=> (index_level == $past(index_in)));

endmodule

// File: tb/test_qenc_position_tracker.sv
`timescale 1ns/1ps
module test_qenc_position_tracker;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phase_a = 1'b0, phase_b = 1'b0, index_in = 1'b0;
  logic [2:0] mode = 3'b000, idx_match = 3'b000;
  logic idx_reset_en = 1'b0, err_irq_dis = 1'b0, err_clear = 1'b0;
  logic [CNT_W-1:0] max_count = '0;
  logic [CNT_W-1:0] position;
  logic index_level, direction, count_err, irq_err, irq_index;

  int errors = 0;
  int checks = 0;
  logic [1:0] ab = 2'b00;

  always #4 clk = ~clk;

  qenc_position_tracker #(.CNT_W(CNT_W)) i_qenc_position_tracker (
    .clk(clk), .rst(rst), .phase_a(phase_a), .phase_b(phase_b),
    .index_in(index_in), .mode(mode), .idx_reset_en(idx_reset_en),
    .idx_match(idx_match), .max_count(max_count), .err_irq_dis(err_irq_dis),
    .err_clear(err_clear), .position(position), .index_level(index_level),
    .direction(direction), .count_err(count_err), .irq_err(irq_err),
    .irq_index(irq_index)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic move(input bit up);
    case (ab)
      2'b00: ab = up ? 2'b10 : 2'b01;
      2'b10: ab = up ? 2'b11 : 2'b00;
      2'b11: ab = up ? 2'b01 : 2'b10;
      default: ab = up ? 2'b00 : 2'b11;
    endcase
    {phase_a, phase_b} = ab;
    tick();
  endtask

  task automatic do_reset();
    ab = 2'b00;
    {phase_a, phase_b} = ab;
    index_in = 1'b0; err_clear = 1'b0; err_irq_dis = 1'b0;
    rst = 1'b1;
    tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 reset position", position, 0);
    chk("R12 reset err", count_err, 0);
    chk("R12 reset irq", {irq_err, irq_index}, 0);
  endtask

  task automatic t_x4();
    mode = 3'b111; max_count = 16'd1000; do_reset();
    for (int i = 0; i < 4; i++) move(1);
    chk("R1 x4 up count", position, 4);
    chk("R1 dir up", direction, 1);
    move(0); move(0);
    chk("R1 x4 down count", position, 2);
    chk("R1 dir down", direction, 0);
  endtask

  task automatic t_x2();
    mode = 3'b101; max_count = 16'd1000; do_reset();
    move(1);
    chk("R2 A edge counts", position, 1);
    move(1);
    chk("R2 B edge ignored", position, 1);
    move(1); move(1);
    chk("R2 full cycle", position, 2);
  endtask

  task automatic t_illegal();
    mode = 3'b111; max_count = 16'd1000; do_reset();
    ab = 2'b11; {phase_a, phase_b} = ab; tick();
    chk("R3 double change", position, 0);
    mode = 3'b000; move(1); move(1);
    chk("R3 mode off", position, 0);
  endtask

  task automatic t_wrap();
    mode = 3'b111; max_count = 16'd5; do_reset();
    for (int i = 0; i < 5; i++) move(1);
    chk("R4 at bound", position, 5);
    move(1);
    chk("R4 wrap up", position, 0);
    move(0);
    chk("R4 wrap down", position, 5);
  endtask

  task automatic t_index_explicit();
    mode = 3'b110; idx_reset_en = 1'b1; idx_match = 3'b100; max_count = 16'd1000;
    do_reset();
    move(1);
    index_in = 1'b1; tick();
    chk("R6 wrong state no reset", position, 1);
    chk("R6 wrong state no irq", irq_index, 0);
    chk("R9 index level high", index_level, 1);
    index_in = 1'b0; tick();
    chk("R9 index level low", index_level, 0);
    move(1); move(1);
    chk("R5 pre-index count", position, 3);
    index_in = 1'b1; move(1);
    chk("R5 index beats step", position, 0);
    chk("R8 irq index pulse", irq_index, 1);
    tick();
    chk("R8 irq index one cycle", irq_index, 0);
    index_in = 1'b0; tick();
  endtask

  task automatic t_index_noreset();
    mode = 3'b110; idx_reset_en = 1'b0; idx_match = 3'b111; max_count = 16'd1000;
    do_reset();
    move(1); move(1);
    index_in = 1'b1; tick();
    chk("R8 irq without reset", irq_index, 1);
    chk("R4 index ignored count", position, 2);
    index_in = 1'b0; tick();
  endtask

  task automatic t_index_auto();
    mode = 3'b110; idx_reset_en = 1'b1; idx_match = 3'b000; max_count = 16'd1000;
    do_reset();
    move(1);
    index_in = 1'b1; tick();
    chk("R7 first pulse resets", position, 0);
    index_in = 1'b0; tick();
    move(1);
    index_in = 1'b1; tick();
    chk("R7 other state ignored", position, 1);
    chk("R7 no irq other state", irq_index, 0);
    index_in = 1'b0; tick();
    move(1); move(1); move(1);
    chk("R7 count before match", position, 4);
    index_in = 1'b1; tick();
    chk("R7 captured state resets", position, 0);
    index_in = 1'b0; tick();
  endtask

  task automatic t_error();
    mode = 3'b110; idx_reset_en = 1'b1; idx_match = 3'b100; max_count = 16'd3;
    do_reset();
    move(1); move(1); move(1);
    chk("R10 no error below bound", count_err, 0);
    move(1);
    chk("R10 bound+1 sets error", count_err, 1);
    chk("R11 irq pulse", irq_err, 1);
    chk("R10 count value", position, 4);
    move(1);
    chk("R10 keeps counting", position, 5);
    chk("R11 no repeat irq", irq_err, 0);
    err_clear = 1'b1; tick(); err_clear = 1'b0;
    chk("R12 clear", count_err, 0);
    move(0); move(0);
    move(1);
    chk("R11 new error irq", irq_err, 1);
    move(0);
    err_clear = 1'b1; move(1); err_clear = 1'b0;
    chk("R11 clear loses to error", count_err, 1);
    chk("R11 irq with clear", irq_err, 1);
    err_clear = 1'b1; tick(); err_clear = 1'b0;
    err_irq_dis = 1'b1;
    move(0); move(1);
    chk("R11 disabled flag", count_err, 1);
    chk("R11 disabled irq", irq_err, 0);
    do_reset();
    move(0);
    chk("R10 underflow value", position, 16'hFFFF);
    chk("R10 underflow error", count_err, 1);
  endtask

  bit done = 0;

  initial begin
    tick();
    t_reset();
    t_x4();
    t_x2();
    t_illegal();
    t_wrap();
    t_index_explicit();
    t_index_noreset();
    t_index_auto();
    t_error();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule